// File: doc/BRIEF.md
# Serial Audio Control Receiver

This block is the digital control front end of a stereo audio processor. A host writes settings over a three-wire serial link: an active-low enable, a serial clock and a data line. The receiver brings the three wires into the system clock domain, shifts in the data bits, and checks a two-bit device address taken from the first two bits of each frame. When enable is released, it stores a six-bit setting into one of eight control registers. Three function bits, carried just ahead of the setting, choose the register.

The eight registers hold four independent fader levels, a master volume, treble and bass tone settings, and a source selector. Their registered outputs go to the downstream attenuator and switch control. A frame may carry any number of padding bits between the address and the final nine bits, and only the final nine bits are used. Out-of-range codes are clamped when the register is written, so the outputs always hold legal levels. Each commit produces a one-cycle update strobe together with the index of the function that was written.

Top module: `audio_ctl_rx`

## Requirements
- R1: While `rst` is high, and after it is released, volume and all four faders read 0, treble and bass read 6 (flat), and the source selector reads 0 (open).
- R2: A data bit enters the frame only on a rising serial clock edge while enable is low. Serial clock edges while enable is high change no output.
- R3: The first two bits of a frame are the device address and must be 1 then 0. Frames with any other address change no register and produce no strobe.
- R4: A falling edge on enable discards the address and bit count of the previous frame. A frame that starts with a wrong address commits nothing, even if an earlier frame had a correct address.
- R5: On the rising edge of enable, the last nine bits received are split into a function field (first three bits, MSB first) and a six-bit value (MSB first). A frame of fewer than eleven bits commits nothing.
- R6: Any number of padding bits may come between the address and the final nine bits. They do not affect the committed value.
- R7: Function codes: 7 left-rear fader, 6 right-rear fader, 5 left-front fader, 4 right-front fader, 3 volume, 2 treble, 1 bass, 0 source selector. A commit writes only the addressed register.
- R8: Volume takes all six value bits, with a legal range of 0 to 41 (2 dB per step, 40 and 41 both 0 dB). Values above 41 are stored as 41.
- R9: A fader takes the low five value bits, and the top bit is ignored. Values above 21 are stored as 21.
- R10: Treble and bass take the low four value bits (6 is flat). Values above 12 are stored as 12.
- R11: The source selector takes the low four value bits. Values 1 to 4 select that input. The value 0 and any value above 4 are stored as 0 (open).
- R12: Each commit raises `upd_o` for exactly one system clock cycle, with `upd_func_o` set to the function code. The register outputs change in that same cycle: the fourth system clock edge after enable rises at the pin. No register output changes in any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous to clk |
| ser_dat_i | input | 1 | Serial data, sampled on serial clock rise |
| ser_en_n_i | input | 1 | Active-low frame enable |
| vol_o | output | 6 | Volume setting |
| treble_o | output | 6 | Treble setting |
| bass_o | output | 6 | Bass setting |
| src_sel_o | output | 6 | Source selector (0 open, 1..4 inputs) |
| fade_lr_o | output | 6 | Left-rear fader level |
| fade_rr_o | output | 6 | Right-rear fader level |
| fade_lf_o | output | 6 | Left-front fader level |
| fade_rf_o | output | 6 | Right-front fader level |
| upd_o | output | 1 | One-cycle commit strobe |
| upd_func_o | output | 3 | Function code of the latest commit |

## Verification
A wrong bit count or stale address shows up the moment enable rises. A frame is then either committed when it should be dropped, or dropped when it should be committed. A bad decode writes a neighbouring register, and all eight outputs are compared against the model on every system clock. Because the outputs respond only at commits, each fault becomes visible exactly four system clocks after the enable rise that exposes it. Clamp and field-width faults show as out-of-range or wrong values in that same cycle.

// File: rtl/audio_ctl_pkg.sv
package audio_ctl_pkg;

  localparam int ADDR_W    = 2;
  localparam int FUNC_W    = 3;
  localparam int VAL_W     = 6;
  localparam int WORD_W    = FUNC_W + VAL_W;
  localparam int FRAME_MIN = ADDR_W + WORD_W;
  localparam int NUM_FUNC  = 1 << FUNC_W;
  localparam int CNT_W     = $clog2(FRAME_MIN + 1);

  localparam logic [ADDR_W-1:0] DEV_ADDR = 2'b10;

  localparam int FADER_MAX = 21;
  localparam int VOL_MAX   = 41;
  localparam int TONE_MAX  = 12;
  localparam int TONE_FLAT = 6;
  localparam int SRC_MAX   = 4;

  typedef enum logic [FUNC_W-1:0] {
    F_SRC     = 3'd0,
    F_BASS    = 3'd1,
    F_TREB    = 3'd2,
    F_VOL     = 3'd3,
    F_FADE_RF = 3'd4,
    F_FADE_LF = 3'd5,
    F_FADE_RR = 3'd6,
    F_FADE_LR = 3'd7
  } func_e;

  typedef logic [VAL_W-1:0] setting_t;

  // Legalise a raw value for the given function.
  function automatic setting_t clamp_setting(func_e f, setting_t raw);
    setting_t r;
    case (f)
      F_SRC: begin
        if (raw[3:0] >= 4'd1 && raw[3:0] <= 4'(SRC_MAX)) r = {2'b00, raw[3:0]};
        else                                            r = '0;
      end
      F_BASS, F_TREB: begin
        if (raw[3:0] > 4'(TONE_MAX)) r = setting_t'(TONE_MAX);
        else                         r = {2'b00, raw[3:0]};
      end
      F_VOL: begin
        if (raw > setting_t'(VOL_MAX)) r = setting_t'(VOL_MAX);
        else                           r = raw;
      end
      default: begin
        if (raw[4:0] > 5'(FADER_MAX)) r = setting_t'(FADER_MAX);
        else                          r = {1'b0, raw[4:0]};
      end
    endcase
    return r;
  endfunction

  function automatic setting_t reset_setting(func_e f);
    if (f == F_BASS || f == F_TREB) return setting_t'(TONE_FLAT);
    return '0;
  endfunction

endpackage

// File: rtl/actl_sync.sv
module actl_sync #(
  parameter int            W       = 3,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stg
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= RST_VAL;
          else     stg[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= RST_VAL;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stg[STAGES-1];

endmodule

// File: rtl/actl_frame.sv
module actl_frame
  import audio_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              sdat_s,
  input  logic              sen_n_s,
  output logic              commit_v_o,
  output logic [WORD_W-1:0] commit_word_o
);

  logic              prev_clk, prev_en_n;
  logic              clk_rise, en_fall, en_rise;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;
  logic              addr_hi, addr_ok;

  assign clk_rise = sclk_s & ~prev_clk;
  assign en_fall  = ~sen_n_s & prev_en_n;
  assign en_rise  = sen_n_s & ~prev_en_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_clk  <= 1'b0;
      prev_en_n <= 1'b1;
    end else begin
      prev_clk  <= sclk_s;
      prev_en_n <= sen_n_s;
    end
  end

  // Bit capture: address from the head, word from the tail.
  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      bit_cnt <= '0;
      addr_hi <= 1'b0;
      addr_ok <= 1'b0;
    end else if (en_fall) begin
      bit_cnt <= '0;
      addr_ok <= 1'b0;
    end else if (clk_rise && !sen_n_s) begin
      shreg <= {shreg[WORD_W-2:0], sdat_s};
      if (bit_cnt != CNT_W'(FRAME_MIN)) bit_cnt <= bit_cnt + 1'b1;
      if (bit_cnt == CNT_W'(0)) addr_hi <= sdat_s;
      if (bit_cnt == CNT_W'(1)) addr_ok <= ({addr_hi, sdat_s} == DEV_ADDR);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      commit_v_o    <= 1'b0;
      commit_word_o <= '0;
    end else begin
      commit_v_o <= en_rise && addr_ok && (bit_cnt == CNT_W'(FRAME_MIN));
      if (en_rise) commit_word_o <= shreg;
    end
  end

endmodule

// File: rtl/actl_regbank.sv
module actl_regbank
  import audio_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              commit_v_i,
  input  logic [WORD_W-1:0] commit_word_i,
  output setting_t          settings_o [NUM_FUNC],
  output logic              upd_o,
  output logic [FUNC_W-1:0] upd_func_o
);

  logic [FUNC_W-1:0] w_func;
  setting_t          w_val;

  assign w_func = commit_word_i[WORD_W-1 -: FUNC_W];
  assign w_val  = commit_word_i[VAL_W-1:0];

  generate
    for (genvar g = 0; g < NUM_FUNC; g++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)
          settings_o[g] <= reset_setting(func_e'(FUNC_W'(g)));
        else if (commit_v_i && w_func == FUNC_W'(g))
          settings_o[g] <= clamp_setting(func_e'(FUNC_W'(g)), w_val);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_o      <= 1'b0;
      upd_func_o <= '0;
    end else begin
      upd_o <= commit_v_i;
      if (commit_v_i) upd_func_o <= w_func;
    end
  end

endmodule

// File: rtl/audio_ctl_rx.sv
module audio_ctl_rx
  import audio_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ser_clk_i,
  input  logic                 ser_dat_i,
  input  logic                 ser_en_n_i,
  output logic [VAL_W-1:0]     vol_o,
  output logic [VAL_W-1:0]     treble_o,
  output logic [VAL_W-1:0]     bass_o,
  output logic [VAL_W-1:0]     src_sel_o,
  output logic [VAL_W-1:0]     fade_lr_o,
  output logic [VAL_W-1:0]     fade_rr_o,
  output logic [VAL_W-1:0]     fade_lf_o,
  output logic [VAL_W-1:0]     fade_rf_o,
  output logic                 upd_o,
  output logic [FUNC_W-1:0]    upd_func_o
);

  localparam int PIN_W = 3;

  logic [PIN_W-1:0]  pins_s;
  logic              commit_v;
  logic [WORD_W-1:0] commit_word;
  setting_t          settings [NUM_FUNC];

  actl_sync #(
    .W       (PIN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({ser_en_n_i, ser_dat_i, ser_clk_i}),
    .sync_o  (pins_s)
  );

  actl_frame u_frame (
    .clk           (clk),
    .rst           (rst),
    .sclk_s        (pins_s[0]),
    .sdat_s        (pins_s[1]),
    .sen_n_s       (pins_s[2]),
    .commit_v_o    (commit_v),
    .commit_word_o (commit_word)
  );

  actl_regbank u_bank (
    .clk           (clk),
    .rst           (rst),
    .commit_v_i    (commit_v),
    .commit_word_i (commit_word),
    .settings_o    (settings),
    .upd_o         (upd_o),
    .upd_func_o    (upd_func_o)
  );

  assign src_sel_o = settings[F_SRC];
  assign bass_o    = settings[F_BASS];
  assign treble_o  = settings[F_TREB];
  assign vol_o     = settings[F_VOL];
  assign fade_rf_o = settings[F_FADE_RF];
  assign fade_lf_o = settings[F_FADE_LF];
  assign fade_rr_o = settings[F_FADE_RR];
  assign fade_lr_o = settings[F_FADE_LR];

endmodule

// File: rtl/audio_ctl_rx_chk.sv
module audio_ctl_rx_chk
  import audio_ctl_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [VAL_W-1:0]  vol_o,
  input logic [VAL_W-1:0]  treble_o,
  input logic [VAL_W-1:0]  bass_o,
  input logic [VAL_W-1:0]  src_sel_o,
  input logic [VAL_W-1:0]  fade_lr_o,
  input logic [VAL_W-1:0]  fade_rr_o,
  input logic [VAL_W-1:0]  fade_lf_o,
  input logic [VAL_W-1:0]  fade_rf_o,
  input logic              upd_o,
  input logic [FUNC_W-1:0] upd_func_o
);

  p_reset_defaults_r1: assert property (@(posedge clk)
    rst |=> (vol_o == '0 && fade_lr_o == '0 && fade_rr_o == '0 && fade_lf_o == '0 &&
             fade_rf_o == '0 && src_sel_o == '0 &&
             treble_o == VAL_W'(TONE_FLAT) && bass_o == VAL_W'(TONE_FLAT)));

  p_vol_max_r8: assert property (@(posedge clk) disable iff (rst)
    vol_o <= VAL_W'(VOL_MAX));

  p_fader_max_r9: assert property (@(posedge clk) disable iff (rst)
    fade_lr_o <= VAL_W'(FADER_MAX) && fade_rr_o <= VAL_W'(FADER_MAX) &&
    fade_lf_o <= VAL_W'(FADER_MAX) && fade_rf_o <= VAL_W'(FADER_MAX));

  p_tone_max_r10: assert property (@(posedge clk) disable iff (rst)
    treble_o <= VAL_W'(TONE_MAX) && bass_o <= VAL_W'(TONE_MAX));

  p_src_range_r11: assert property (@(posedge clk) disable iff (rst)
    src_sel_o <= VAL_W'(SRC_MAX));

  p_upd_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    upd_o |=> !upd_o);

  p_vol_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (!upd_o || upd_func_o != F_VOL) |-> $stable(vol_o));

  p_src_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (!upd_o || upd_func_o != F_SRC) |-> $stable(src_sel_o));

  p_fade_lr_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!upd_o || upd_func_o != F_FADE_LR) |-> $stable(fade_lr_o));

endmodule

bind audio_ctl_rx audio_ctl_rx_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .vol_o      (vol_o),
  .treble_o   (treble_o),
  .bass_o     (bass_o),
  .src_sel_o  (src_sel_o),
  .fade_lr_o  (fade_lr_o),
  .fade_rr_o  (fade_rr_o),
  .fade_lf_o  (fade_lf_o),
  .fade_rf_o  (fade_rf_o),
  .upd_o      (upd_o),
  .upd_func_o (upd_func_o)
);

// File: tb/tb_audio_ctl_rx.sv
module tb_audio_ctl_rx;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_clk = 1'b0;
  logic       ser_dat = 1'b0;
  logic       ser_en_n = 1'b1;
  logic [5:0] vol_o, treble_o, bass_o, src_sel_o;
  logic [5:0] fade_lr_o, fade_rr_o, fade_lf_o, fade_rf_o;
  logic       upd_o;
  logic [2:0] upd_func_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit live   = 0;

  always #5 clk = ~clk;

  audio_ctl_rx dut (
    .clk(clk), .rst(rst),
    .ser_clk_i(ser_clk), .ser_dat_i(ser_dat), .ser_en_n_i(ser_en_n),
    .vol_o(vol_o), .treble_o(treble_o), .bass_o(bass_o), .src_sel_o(src_sel_o),
    .fade_lr_o(fade_lr_o), .fade_rr_o(fade_rr_o), .fade_lf_o(fade_lf_o),
    .fade_rf_o(fade_rf_o), .upd_o(upd_o), .upd_func_o(upd_func_o)
  );

  // Behavioural reference model
  int   m_reg [8];
  bit   m_upd = 0;
  int   m_idx = 0;
  bit   m_bits [$];
  logic [51:0] pipe [4];

  function automatic int legal(int f, int v);
    int lo4 = v % 16;
    int lo5 = v % 32;
    if (f >= 4) return (lo5 > 21) ? 21 : lo5;
    if (f == 3) return (v > 41) ? 41 : v;
    if (f == 0) return (lo4 >= 1 && lo4 <= 4) ? lo4 : 0;
    return (lo4 > 12) ? 12 : lo4;
  endfunction

  function automatic logic [51:0] pack_model();
    logic [51:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) p[i*6 +: 6] = 6'(m_reg[i]);
    p[48]    = m_upd;
    p[51:49] = 3'(m_idx);
    return p;
  endfunction

  function automatic logic [5:0] dut_val(int f);
    case (f)
      0: return src_sel_o;
      1: return bass_o;
      2: return treble_o;
      3: return vol_o;
      4: return fade_rf_o;
      5: return fade_lf_o;
      6: return fade_rr_o;
      default: return fade_lr_o;
    endcase
  endfunction

  function automatic string tag_of(int f);
    if (f >= 4) return "R9";
    if (f == 3) return "R8";
    if (f == 0) return "R11";
    return "R10";
  endfunction

  // Model output history: outputs follow the model four clocks later (R12)
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) pipe[i] <= pack_model();
    end else begin
      pipe[0] <= pack_model();
      pipe[1] <= pipe[0];
      pipe[2] <= pipe[1];
      pipe[3] <= pipe[2];
    end
  end

  // Per-cycle comparison
  always @(negedge clk) begin
    if (live && !done) begin
      logic [51:0] e;
      bit bad;
      e = pipe[3];
      bad = 0;
      checks++;
      for (int i = 0; i < 8; i++) begin
        if (dut_val(i) !== e[i*6 +: 6]) begin
          $display("FAIL %s cycle compare func %0d: actual %0d expected %0d",
                   tag_of(i), i, dut_val(i), e[i*6 +: 6]);
          bad = 1;
        end
      end
      if (upd_o !== e[48] || (e[48] && upd_func_o !== e[51:49])) begin
        $display("FAIL R12 strobe: actual upd=%0b func=%0d expected upd=%0b func=%0d",
                 upd_o, upd_func_o, e[48], e[51:49]);
        bad = 1;
      end
      if (bad) fails++;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic en_low();
    ser_en_n = 1'b0;
    m_bits.delete();
    cyc(6);
  endtask

  task automatic en_high();
    ser_en_n = 1'b1;
    if (m_bits.size() >= 11 && m_bits[0] == 1'b1 && m_bits[1] == 1'b0) begin
      int n = m_bits.size();
      int f = 0;
      int v = 0;
      for (int k = n - 9; k < n - 6; k++) f = f * 2 + int'(m_bits[k]);
      for (int k = n - 6; k < n; k++)     v = v * 2 + int'(m_bits[k]);
      m_reg[f] = legal(f, v);
      m_idx = f;
      m_upd = 1;
      cyc(1);
      m_upd = 0;
      cyc(9);
    end else begin
      cyc(10);
    end
  endtask

  task automatic send_bits(logic [31:0] vec, int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = vec[i];
      cyc(4);
      ser_clk = 1'b1;
      if (ser_en_n == 1'b0) m_bits.push_back(vec[i]);
      cyc(4);
      ser_clk = 1'b0;
    end
    cyc(2);
  endtask

  task automatic frame(logic [1:0] a, int npad, logic [15:0] pad, int f, int v);
    logic [31:0] vec;
    vec = (32'(a) << (9 + npad)) | ((32'(pad) & ((32'd1 << npad) - 1)) << 9)
        | (32'(f) << 6) | 32'(v);
    en_low();
    send_bits(vec, 11 + npad);
    en_high();
  endtask

  task automatic chk(string tag, int f, int expv);
    checks++;
    if (dut_val(f) !== 6'(expv)) begin
      fails++;
      $display("FAIL %s func %0d: actual %0d expected %0d", tag, f, dut_val(f), expv);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      done = 1;
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m_reg[i] = (i == 1 || i == 2) ? 6 : 0;
    cyc(6);
    // R1: defaults seen during reset
    chk("R1", 3, 0); chk("R1", 2, 6); chk("R1", 1, 6);
    rst = 1'b0;
    cyc(2);
    live = 1;
    for (int i = 4; i < 8; i++) chk("R1", i, 0);
    chk("R1", 0, 0);

    // R5 / R7: basic writes to each function
    frame(2'b10, 0, 0, 3, 20);  chk("R5", 3, 20);
    frame(2'b10, 0, 0, 2, 9);   chk("R7", 2, 9);
    frame(2'b10, 0, 0, 1, 3);   chk("R7", 1, 3);
    frame(2'b10, 0, 0, 0, 3);   chk("R7", 0, 3);
    frame(2'b10, 0, 0, 7, 10);  chk("R7", 7, 10);
    frame(2'b10, 0, 0, 6, 15);  chk("R7", 6, 15);
    frame(2'b10, 0, 0, 5, 6'b110101); chk("R9", 5, 21);
    frame(2'b10, 0, 0, 4, 5);   chk("R7", 4, 5); chk("R7", 3, 20);

    // R8: volume clamp
    frame(2'b10, 0, 0, 3, 63);  chk("R8", 3, 41);
    frame(2'b10, 0, 0, 3, 40);  chk("R8", 3, 40);
    frame(2'b10, 0, 0, 3, 41);  chk("R8", 3, 41);
    // R9: fader top bit ignored and clamp
    frame(2'b10, 0, 0, 7, 6'b011111); chk("R9", 7, 21);
    frame(2'b10, 0, 0, 6, 6'b100011); chk("R9", 6, 3);
    // R10: tone field and clamp
    frame(2'b10, 0, 0, 2, 6'b001111); chk("R10", 2, 12);
    frame(2'b10, 0, 0, 1, 6'b110101); chk("R10", 1, 5);
    // R11: source selector mapping
    frame(2'b10, 0, 0, 0, 6'b000111); chk("R11", 0, 0);
    frame(2'b10, 0, 0, 0, 6'b110010); chk("R11", 0, 2);
    frame(2'b10, 0, 0, 0, 4);   chk("R11", 0, 4);
    frame(2'b10, 0, 0, 0, 5);   chk("R11", 0, 0);

    // R3: wrong device addresses commit nothing
    frame(2'b11, 0, 0, 3, 7);   chk("R3", 3, 41);
    frame(2'b01, 0, 0, 3, 7);   chk("R3", 3, 41);
    frame(2'b00, 0, 0, 2, 0);   chk("R3", 2, 12);

    // R5: a ten-bit frame commits nothing
    en_low(); send_bits(32'b10_011_00101, 10); en_high();
    chk("R5", 3, 41);

    // R6: padding between address and word
    frame(2'b10, 5, 16'b10110, 3, 17); chk("R6", 3, 17);
    frame(2'b10, 13, 16'h1A5B, 2, 8);  chk("R6", 2, 8);

    // R4: address from a previous frame is discarded
    en_low(); send_bits(32'b10, 2); en_high();
    chk("R4", 3, 17);
    frame(2'b00, 0, 0, 3, 33);  chk("R4", 3, 33 == 0 ? 0 : 17);

    // R2: serial clocks while enable is high are ignored
    send_bits(32'b10_011_000011, 11);
    chk("R2", 3, 17);
    en_low(); en_high();
    chk("R2", 3, 17);
    frame(2'b10, 0, 0, 3, 2);   chk("R2", 3, 2);

    // R12: back-to-back commits keep the one-cycle strobe
    frame(2'b10, 0, 0, 4, 21);  chk("R12", 4, 21);
    frame(2'b10, 0, 0, 5, 0);   chk("R12", 5, 0);

    cyc(8);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule